// File: doc/BRIEF.md
# Bit Centrifuge Unit

This unit takes a 64-bit data word and a 64-bit mask word. It separates the data bits into two groups according to the mask bit at the same position. Data bits whose mask bit is 1 are gathered at the low end of the result. Data bits whose mask bit is 0 are gathered at the high end. Each group keeps the relative order its bits had in the data word. The two groups always fill the 64 result bits exactly. The operation has no flags and no status output; the only product is the 64-bit result.

Operands arrive on a valid/ready handshake, and a new pair may be accepted on every clock. Two running-count networks give each data bit its destination index, and a 64-way scatter places the bits at those indices. The scatter result is captured in an output register that has a valid flag. A small two-state controller runs that register:

- ST_EMPTY: no result is held. A handshake in this state (EMPTY_TO_FULL) loads the register. With no handshake the controller stays in ST_EMPTY (EMPTY_HOLD).
- ST_FULL: a result is presented. The controller stays in ST_FULL when the consumer takes the result and a new pair is accepted in the same cycle (FULL_REFILL), or when the consumer stalls (FULL_STALL). It returns to ST_EMPTY when the result is taken and no new pair arrives (FULL_TO_EMPTY).

Top module: `bit_centrifuge`

## Requirements
- R1: A pair is accepted on a rising edge where in_valid and in_ready are both 1. On the next edge out_valid is 1 and out_result holds that pair's result. Pairs may be accepted on consecutive cycles.
- R2: Let P be the number of 1 bits in the mask. Result bits 0 to P-1 hold the data bits whose mask bit is 1, in ascending order of their original position. The lowest such data bit goes to result bit 0.
- R3: Result bits P to 63 hold the data bits whose mask bit is 0, in ascending order of their original position. The highest such data bit goes to result bit 63.
- R4: The result is a permutation of the data word. The mask-one and mask-zero groups together cover exactly 64 positions, and the result has the same number of 1 bits as the data.
- R5: When the mask is all zeros or all ones, the result equals the data word.
- R6: in_ready is 1 whenever out_valid is 0 or out_ready is 1. It is 0 when out_valid is 1 and out_ready is 0.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_result does not change on the next edge.
- R8: A synchronous active-high rst clears out_valid at the next rising edge, which puts the controller in ST_EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| in_data | input | 64 | Data word to be split |
| in_mask | input | 64 | Mask word selecting the group of each data bit |
| out_valid | output | 1 | out_result holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Registered result word |

## Verification
The assertions assume that in_data and in_mask are known values in every cycle where in_valid is 1. They also assume that rst is asserted at the first clock edge, so the controller starts from a defined state. The stimulus drives both inputs only at falling edges and never leaves an operand undefined while in_valid is high. It keeps rst high for several edges at the start. It exercises stalls only by holding out_ready low, never by changing operands under a pending handshake, so every pair that is accepted is one the bench has already recorded.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;
endpackage

// File: rtl/bc_prefix_count.sv
module bc_prefix_count #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         vec,
    output logic [W-1:0][CW-1:0] below,
    output logic [CW-1:0]        total
);
    // Exclusive running count: below[i] = number of set bits at positions < i
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < W; i++) begin
            below[i] = acc;
            acc = acc + CW'(vec[i]);
        end
        total = acc;
    end

    // R4: the running total agrees with an independent population count
    p_total_matches_r4: assert property (@(posedge clk) disable iff (rst)
        32'(total) == $countones(vec));
endmodule

// File: rtl/bc_scatter.sv
module bc_scatter #(
    parameter int W  = 64,
    parameter int DW = $clog2(W)
) (
    input  logic [W-1:0]         data,
    input  logic [W-1:0][DW-1:0] dest,
    output logic [W-1:0]         result
);
    always_comb begin
        result = '0;
        for (int i = 0; i < W; i++) begin
            result[dest[i]] = data[i];
        end
    end
endmodule

// File: rtl/bc_out_stage.sv
module bc_out_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] next_result,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    import bc_pkg::*;

    out_state_t state_q, state_d;
    logic       fire;

    assign fire = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (fire) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !fire) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (fire) out_result <= next_result;
    end

    // R8: reset empties the output register
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> !out_valid);
    // R1: an accepted pair yields a valid result one edge later
    p_fire_valid_r1: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);
    // R6: ready whenever nothing is held
    p_ready_empty_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
    // R6: a stalled result blocks input
    p_ready_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
    // R7: a stalled result is held unchanged
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
endmodule

// File: rtl/bit_centrifuge.sv
module bit_centrifuge #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] in_mask,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_result
);
    localparam int CW = $clog2(W) + 1;
    localparam int DW = $clog2(W);

    logic [W-1:0][CW-1:0] one_below, zero_below;
    logic [CW-1:0]        one_total, zero_total;
    logic [W-1:0][DW-1:0] dest;
    logic [W-1:0]         packed_word;

    bc_prefix_count #(.W(W), .CW(CW)) u_ones (
        .clk   (clk),
        .rst   (rst),
        .vec   (in_mask),
        .below (one_below),
        .total (one_total)
    );

    bc_prefix_count #(.W(W), .CW(CW)) u_zeros (
        .clk   (clk),
        .rst   (rst),
        .vec   (~in_mask),
        .below (zero_below),
        .total (zero_total)
    );

    // Mask-one bits go from the bottom up; mask-zero bits follow them
    generate
        for (genvar g = 0; g < W; g++) begin : g_dest
            logic [CW-1:0] zero_slot;
            assign zero_slot = one_total + zero_below[g];
            assign dest[g] = in_mask[g] ? one_below[g][DW-1:0] : zero_slot[DW-1:0];
        end
    endgenerate

    bc_scatter #(.W(W), .DW(DW)) u_scatter (
        .data   (in_data),
        .dest   (dest),
        .result (packed_word)
    );

    bc_out_stage #(.W(W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .next_result (packed_word),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_result  (out_result)
    );

    // R4: the two groups fill the word exactly
    p_groups_fill_r4: assert property (@(posedge clk) disable iff (rst)
        32'(one_total) + 32'(zero_total) == W);
    // R4: ones in the data are preserved in the result
    p_popcount_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> $countones(out_result) == $countones($past(in_data)));
    // R5: uniform masks pass the data through unchanged
    p_uniform_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (in_mask == '0 || in_mask == '1))
        |=> out_result == $past(in_data));
endmodule

// File: tb/tb_bit_centrifuge.sv
module tb_bit_centrifuge;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [63:0] in_data, in_mask, out_result;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    bit_centrifuge dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mask(in_mask), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result)
    );

    function automatic logic [63:0] ref_model(logic [63:0] d, logic [63:0] m);
        logic [63:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < 64; i++) if (m[i])  begin r[k] = d[i]; k++; end
        for (int i = 0; i < 64; i++) if (!m[i]) begin r[k] = d[i]; k++; end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One isolated operation: drive, then check one edge later (R1, R2, R3, R4)
    task automatic apply_one(string req, logic [63:0] d, logic [63:0] m);
        logic [63:0] e;
        e = ref_model(d, m);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_mask = m; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R1 valid"}, 64'(out_valid), 64'd1);
        chk(req, out_result, e);
        chk({req, " R4 popcount"}, 64'($countones(out_result)), 64'($countones(d)));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0; in_mask = '0;
        repeat (3) @(negedge clk);
        chk("R8 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R6 in_ready when empty", 64'(in_ready), 64'd1);
        rst = 1'b0;
    endtask

    task automatic t_uniform;
        apply_one("R5 zero mask", 64'h0123_4567_89AB_CDEF, 64'h0);
        chk("R5 zero mask passthrough", out_result, 64'h0123_4567_89AB_CDEF);
        apply_one("R5 ones mask", 64'hDEAD_BEEF_F00D_1234, '1);
        chk("R5 ones mask passthrough", out_result, 64'hDEAD_BEEF_F00D_1234);
    endtask

    task automatic t_single_bit;
        int pos [5] = '{0, 1, 31, 62, 63};
        foreach (pos[n]) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            apply_one("R2 single-bit mask", d, 64'd1 << pos[n]);
            chk("R2 single mask bit lands at bit 0", 64'(out_result[0]), 64'(d[pos[n]]));
        end
        // mask bit 0 only, data bit 0 only: the data bit stays at 0, rest zero
        apply_one("R3 single-bit known", 64'h1, 64'h1);
        chk("R3 known value", out_result, 64'h1);
        // data top bit with zero mask there lands on bit 63 (R3)
        apply_one("R3 top zero bit", 64'h8000_0000_0000_0000, 64'h1);
        chk("R3 top bit to 63", 64'(out_result[63]), 64'd1);
    endtask

    task automatic t_alternating;
        apply_one("R2 R3 alt 5555", 64'hFFFF_FFFF_0000_0000, 64'h5555_5555_5555_5555);
        // even data bits in the upper half go to group positions 16..31; odd ones fill 48..63
        chk("R2 R3 alt known", out_result, 64'hFFFF_0000_FFFF_0000);
        apply_one("R2 R3 alt AAAA", 64'h0F0F_3C3C_A5A5_1234, 64'hAAAA_AAAA_AAAA_AAAA);
    endtask

    // Back-to-back stream: a pair every cycle, R1 throughput
    task automatic t_stream(int n);
        logic [63:0] e;
        bit pend;
        pend = 0;
        e = '0;
        for (int k = 0; k < n; k++) begin
            logic [63:0] d, m;
            d = {$urandom, $urandom};
            m = {$urandom, $urandom};
            @(negedge clk);
            if (pend) begin
                chk("R1 stream valid", 64'(out_valid), 64'd1);
                chk("R2 R3 stream result", out_result, e);
            end
            in_valid = 1'b1; in_data = d; in_mask = m; out_ready = 1'b1;
            e = ref_model(d, m);
            pend = 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 stream valid last", 64'(out_valid), 64'd1);
        chk("R2 R3 stream last", out_result, e);
    endtask

    task automatic t_backpressure;
        logic [63:0] d1, m1, d2, m2;
        d1 = 64'hCAFE_0000_1111_2222; m1 = 64'h00FF_00FF_F0F0_0F0F;
        d2 = 64'h1357_9BDF_2468_ACE0; m2 = 64'h8000_0000_0000_0001;
        @(negedge clk);
        in_valid = 1'b1; in_data = d1; in_mask = m1; out_ready = 1'b0;
        @(negedge clk);
        in_data = d2; in_mask = m2;
        chk("R6 stalled in_ready low", 64'(in_ready), 64'd0);
        chk("R1 first result", out_result, ref_model(d1, m1));
        @(negedge clk);
        chk("R7 held valid", 64'(out_valid), 64'd1);
        chk("R7 held result", out_result, ref_model(d1, m1));
        out_ready = 1'b1;
        #1;
        chk("R6 ready follows out_ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 second result", out_result, ref_model(d2, m2));
        @(negedge clk);
        chk("R8 drained not valid", 64'(out_valid), 64'd0);
        chk("R6 ready when drained", 64'(in_ready), 64'd1);
    endtask

    task automatic t_midreset;
        apply_one("R2 before reset", 64'h5A5A_5A5A_5A5A_5A5A, 64'h0000_FFFF_0000_FFFF);
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        chk("R8 mid-run reset clears valid", 64'(out_valid), 64'd0);
        out_ready = 1'b1;
    endtask

    initial begin
        t_reset();
        t_uniform();
        t_single_bit();
        t_alternating();
        t_backpressure();
        t_stream(220);
        t_midreset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule